// File: doc/BRIEF.md
# Receive Buffer with Frame-Count Timeout

This block holds 32-bit words produced by an upstream slot packer until a CPU-side reader takes them. It is a first-in first-out store of eight entries. The oldest word is always presented on the read-data port while the buffer holds anything, and a read strobe pops it. A mode input reduces the store to a single holding entry for character-at-a-time operation. Any change of that input discards whatever is buffered.

The block also raises an interrupt when received data sits unread. Each frame marker that arrives while the buffer is non-empty and no new word is accepted advances a frame counter. When the counter reaches a programmed limit, the interrupt is raised. A limit of zero switches the mechanism off. A strobe marking a write of the limit register clears the interrupt and the counter. Draining the buffer to empty also clears both.

Top module: `rx_frame_fifo`

## Requirements
- R1: Words leave in arrival order. While the buffer is non-empty, `rd_data` shows the oldest word, and a read strobe removes it at the next clock edge. In buffered mode (`char_mode` = 0) the buffer holds up to 8 words.
- R2: `empty` is 1 exactly when no word is held, and `full` is 1 exactly when the held count equals the current capacity. A read strobe while empty changes nothing.
- R3: A write strobe when the held count is already at capacity is dropped, even if a read happens in the same cycle. The dropped write sets `overrun` to 1, and `overrun` stays at 1 until reset or a mode change.
- R4: With `char_mode` = 1 the capacity is one word. After that word is accepted, `full` is 1, later writes are dropped, and the held word stays on `rd_data`.
- R5: In any cycle where `char_mode` differs from its value in the previous cycle, the buffer is emptied and `overrun` is cleared. Reads and writes in that cycle are ignored.
- R6: On each cycle with `frame_sync` = 1, with the buffer non-empty, no word accepted, `tmo_limit` non-zero and the interrupt low, the frame count goes up by one. When the count reaches `tmo_limit`, `tmo_irq` goes to 1 after that edge and stays at 1.
- R7: While `tmo_limit` is 0, no frame is counted and `tmo_irq` never rises.
- R8: An accepted write restarts the frame count from zero.
- R9: A `tmo_wr` strobe clears `tmo_irq` and the frame count at the next edge.
- R10: When the buffer becomes empty, `tmo_irq` and the frame count are cleared at the same edge.
- R11: After reset the buffer is empty, is not full, and `overrun` and `tmo_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the slot packer |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read strobe from the CPU side |
| rd_data | output | 32 | Oldest held word, valid while not empty |
| frame_sync | input | 1 | One-cycle pulse once per frame |
| tmo_limit | input | 12 | Frame count that raises the interrupt; 0 turns it off |
| tmo_wr | input | 1 | Pulse when the limit register is written |
| char_mode | input | 1 | 1 selects the one-entry holding mode |
| empty | output | 1 | Buffer holds no word |
| full | output | 1 | Buffer is at its current capacity |
| overrun | output | 1 | Sticky flag for a dropped write |
| tmo_irq | output | 1 | Timeout interrupt |

## Verification
The assertions check these rules on every cycle: `empty` and `full` are never both high; a one-entry buffer reports full whenever it holds a word; a write at capacity sets the overrun flag; the flag falls only after a mode change; the interrupt is low whenever the buffer is empty and after a limit write; and the interrupt rises only on a frame pulse with a non-zero limit. Other behaviours are only visible across many cycles, so only the bench scenarios show them. These are the exact frame on which the interrupt rises, the restart of the count by new data, the arrival order of words across pointer wrap, and the flush contents on a mode change. The bench compares every output each cycle against a queue-based reference model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // Control state kept by the top level
    typedef struct packed {
        logic char_q;   // mode seen in the previous cycle
        logic ovr;      // sticky dropped-write flag
    } rxf_ctl_t;

    localparam rxf_ctl_t RXF_CTL_RST = '{char_q: 1'b0, ovr: 1'b0};

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          empty_next
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           lvl;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = ptr_next(st_q.wp);
            end
            if (pop) begin
                st_d.rp = ptr_next(st_q.rp);
            end
            st_d.lvl = st_q.lvl + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata      = st_q.mem[st_q.rp];
    assign level      = st_q.lvl;
    assign empty_next = (st_d.lvl == '0);

endmodule

// File: rtl/rxf_frame_timer.sv
module rxf_frame_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync,
    input  logic [CW-1:0] limit,
    input  logic          limit_wr,
    input  logic          word_in,
    input  logic          going_empty,
    output logic          irq
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic [CW:0] cnt_inc;

    assign cnt_inc = {1'b0, tm_q.cnt} + 1'b1;

    always_comb begin
        tm_d = tm_q;
        if (going_empty || limit_wr) begin
            tm_d.cnt = '0;
            tm_d.irq = 1'b0;
        end else if (word_in) begin
            tm_d.cnt = '0;
        end else if (sync && (limit != '0) && !tm_q.irq) begin
            if (cnt_inc >= {1'b0, limit}) begin
                tm_d.irq = 1'b1;
                tm_d.cnt = '0;
            end else begin
                tm_d.cnt = cnt_inc[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign irq = tm_q.irq;

endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int TMO_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_sync,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              tmo_wr,
    input  logic              char_mode,
    output logic              empty,
    output logic              full,
    output logic              overrun,
    output logic              tmo_irq
);
    import rxf_pkg::*;

    localparam int LW = $clog2(DEPTH + 1);

    rxf_ctl_t      ctl_d, ctl_q;
    logic [LW-1:0] level;
    logic [LW-1:0] cap;
    logic          mode_flip;
    logic          room;
    logic          push;
    logic          pop;
    logic          going_empty;

    assign mode_flip = (char_mode != ctl_q.char_q);
    assign cap       = ctl_q.char_q ? LW'(1) : LW'(DEPTH);
    assign room      = (level < cap);
    assign push      = !mode_flip && wr_en && room;
    assign pop       = !mode_flip && rd_en && (level != '0);

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.char_q = char_mode;
        if (mode_flip) begin
            ctl_d.ovr = 1'b0;
        end else if (wr_en && !room) begin
            ctl_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= RXF_CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rxf_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .flush      (mode_flip),
        .wdata      (wr_data),
        .rdata      (rd_data),
        .level      (level),
        .empty_next (going_empty)
    );

    rxf_frame_timer #(.CW(TMO_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync        (frame_sync),
        .limit       (tmo_limit),
        .limit_wr    (tmo_wr),
        .word_in     (push),
        .going_empty (going_empty),
        .irq         (tmo_irq)
    );

    assign empty   = (level == '0);
    assign full    = (level == cap);
    assign overrun = ctl_q.ovr;

endmodule

// File: rtl/rx_frame_fifo_chk.sv
module rx_frame_fifo_chk #(
    parameter int TMO_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             frame_sync,
    input logic [TMO_W-1:0] tmo_limit,
    input logic             tmo_wr,
    input logic             char_mode,
    input logic             empty,
    input logic             full,
    input logic             overrun,
    input logic             tmo_irq
);

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    p_char_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(char_mode) && !empty) |-> full);

    p_drop_sets_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && (char_mode == $past(char_mode))) |=> overrun);

    p_ovr_falls_on_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> ($past(char_mode) != $past(char_mode, 2)));

    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_irq) |-> ($past(frame_sync) && ($past(tmo_limit) != '0)));

    p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmo_limit == '0) && ($past(tmo_limit) == '0) && !$past(tmo_irq)) |-> !tmo_irq);

    p_limit_wr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_wr |=> !tmo_irq);

    p_empty_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !tmo_irq);

endmodule

bind rx_frame_fifo rx_frame_fifo_chk #(.TMO_W(TMO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .frame_sync (frame_sync),
    .tmo_limit  (tmo_limit),
    .tmo_wr     (tmo_wr),
    .char_mode  (char_mode),
    .empty      (empty),
    .full       (full),
    .overrun    (overrun),
    .tmo_irq    (tmo_irq)
);

// File: tb/tb_rx_frame_fifo.sv
module tb_rx_frame_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        frame_sync = 1'b0;
    logic [11:0] tmo_limit = '0;
    logic        tmo_wr = 1'b0;
    logic        char_mode = 1'b0;
    logic        empty, full, overrun, tmo_irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit [31:0] mq[$];
    bit        m_char = 1'b0;
    bit        m_ovr  = 1'b0;
    int        m_cnt  = 0;
    bit        m_irq  = 1'b0;

    always #5 clk = ~clk;

    rx_frame_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .frame_sync(frame_sync),
        .tmo_limit(tmo_limit), .tmo_wr(tmo_wr), .char_mode(char_mode),
        .empty(empty), .full(full), .overrun(overrun), .tmo_irq(tmo_irq)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int cap_of(input bit c);
        return c ? 1 : 8;
    endfunction

    task automatic model_step(input bit w, input bit [31:0] d, input bit r,
                              input bit s, input bit t, input bit cm, input int lim);
        bit wacc;
        wacc = 1'b0;
        if (cm != m_char) begin
            mq.delete();
            m_ovr  = 1'b0;
            m_char = cm;
        end else begin
            int sz;
            sz = mq.size();
            wacc = w && (sz < cap_of(m_char));
            if (w && !wacc) m_ovr = 1'b1;
            if (r && sz > 0) void'(mq.pop_front());
            if (wacc) mq.push_back(d);
        end
        if (mq.size() == 0 || t) begin
            m_cnt = 0;
            m_irq = 1'b0;
        end else if (wacc) begin
            m_cnt = 0;
        end else if (s && lim != 0 && !m_irq) begin
            if (m_cnt + 1 >= lim) begin
                m_irq = 1'b1;
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    task automatic compare_all();
        chk(empty === (mq.size() == 0), "R2", "empty", 32'(empty), 32'(mq.size() == 0));
        chk(full === (mq.size() == cap_of(m_char)), "R2", "full", 32'(full),
            32'(mq.size() == cap_of(m_char)));
        if (mq.size() > 0)
            chk(rd_data === mq[0], "R1", "rd_data", rd_data, mq[0]);
        chk(overrun === m_ovr, "R3", "overrun", 32'(overrun), 32'(m_ovr));
        chk(tmo_irq === m_irq, "R6", "tmo_irq", 32'(tmo_irq), 32'(m_irq));
    endtask

    // drive at falling edge, compare after the following rising edge
    task automatic cyc(input bit w, input bit [31:0] d, input bit r,
                       input bit s, input bit t);
        wr_en = w; wr_data = d; rd_en = r; frame_sync = s; tmo_wr = t;
        model_step(w, d, r, s, t, char_mode, int'(tmo_limit));
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; frame_sync = 1'b0; tmo_wr = 1'b0;
        compare_all();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(empty === 1'b1, "R11", "empty", 32'(empty), 1);
        chk(full === 1'b0, "R11", "full", 32'(full), 0);
        chk(overrun === 1'b0, "R11", "overrun", 32'(overrun), 0);
        chk(tmo_irq === 1'b0, "R11", "tmo_irq", 32'(tmo_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill to eight, ordered readout
        for (int i = 0; i < 8; i++) cyc(1, 32'h100 + i, 0, 0, 0);
        chk(full === 1'b1, "R1", "full after 8", 32'(full), 1);
        // R3: write at capacity with a read in the same cycle is dropped
        cyc(1, 32'hDEAD, 1, 0, 0);
        chk(overrun === 1'b1, "R3", "overrun", 32'(overrun), 1);
        for (int i = 0; i < 7; i++) cyc(0, 0, 1, 0, 0);
        chk(empty === 1'b1, "R1", "empty after drain", 32'(empty), 1);
        // R2: read while empty
        cyc(0, 0, 1, 0, 0);
        chk(empty === 1'b1 && full === 1'b0, "R2", "read when empty", 32'(empty), 1);

        // R6 / R9 / R8 / R10 with limit 3
        tmo_limit = 12'd3;
        cyc(1, 32'hA1, 0, 0, 1);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        chk(tmo_irq === 1'b0, "R6", "irq before limit", 32'(tmo_irq), 0);
        cyc(0, 0, 0, 1, 0);
        chk(tmo_irq === 1'b1, "R6", "irq at limit", 32'(tmo_irq), 1);
        cyc(0, 0, 0, 1, 1);
        chk(tmo_irq === 1'b0, "R9", "irq after limit write", 32'(tmo_irq), 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(1, 32'hA2, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0);
        chk(tmo_irq === 1'b0, "R8", "count restarted", 32'(tmo_irq), 0);
        cyc(0, 0, 0, 1, 0);
        chk(tmo_irq === 1'b1, "R8", "irq after restart", 32'(tmo_irq), 1);
        cyc(0, 0, 1, 0, 0);
        chk(tmo_irq === 1'b1, "R6", "irq held", 32'(tmo_irq), 1);
        cyc(0, 0, 1, 0, 0);
        chk(tmo_irq === 1'b0, "R10", "irq cleared on drain", 32'(tmo_irq), 0);

        // R7: zero limit
        tmo_limit = 12'd0;
        cyc(1, 32'hB0, 0, 0, 1);
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 0);
        chk(tmo_irq === 1'b0, "R7", "no irq with zero limit", 32'(tmo_irq), 0);

        // R5 / R4: switch to holding mode flushes
        char_mode = 1'b1;
        cyc(1, 32'hC0, 0, 0, 0);
        chk(empty === 1'b1, "R5", "flushed on mode change", 32'(empty), 1);
        cyc(1, 32'hC1, 0, 0, 0);
        chk(full === 1'b1, "R4", "one word fills", 32'(full), 1);
        cyc(1, 32'hC2, 0, 0, 0);
        chk(rd_data === 32'hC1, "R4", "held word kept", rd_data, 32'hC1);
        chk(overrun === 1'b1, "R4", "second write dropped", 32'(overrun), 1);
        char_mode = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk(empty === 1'b1 && overrun === 1'b0, "R5", "flush clears overrun",
            32'(overrun), 0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 199) == 0) char_mode = ~char_mode;
            if ($urandom_range(0, 99) == 0) tmo_limit = 12'($urandom_range(0, 5));
            cyc($urandom_range(0, 99) < 45, $urandom, $urandom_range(0, 99) < 35,
                $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 3);
        end
        finish_run();
    end

endmodule